// File: doc/BRIEF.md
# Stuffed-Start Packet Extractor with Packet Watchdog

This block sits behind a byte-wide serial receiver and pulls fixed-length packets out of the incoming byte stream. Each packet opens with one reserved marker value (`start_code`). When a payload byte happens to carry the marker value, the sender transmits it twice, and the block folds the pair back into one payload byte. A single marker that is followed by any other byte always opens a fresh packet and abandons whatever packet was being collected.

When a packet opens, the block starts a cycle counter. The limit should be set a little shorter than the sender's smallest spacing between packet starts. If the payload is still incomplete when the limit runs out, the block voids the packet. It raises a one-cycle drop pulse together with a one-cycle receiver-reset pulse, so that the serial receiver can be cleared of a half-shifted byte. The block then ignores everything until the next marker. Payload bytes leave one cycle after they are sampled, and the final byte of each packet is flagged. Bytes that were already delivered are never withdrawn, so downstream logic must throw away the partial packet when it sees the drop pulse.

Top module: `pkt_deframer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid`, `out_last`, `drop` and `rx_reset` are all 0.
- R2: While no packet is open, every byte is ignored until a valid byte equal to `start_code` arrives. That byte opens a packet and is never delivered as payload.
- R3: Inside a packet, each valid byte not equal to `start_code` is delivered on `out_data` with `out_valid` high for exactly one cycle, in the cycle after it was sampled, and in arrival order.
- R4: Inside a packet, two consecutive valid bytes equal to `start_code` produce one payload byte with the value `start_code`, delivered one cycle after the second byte was sampled. This also applies to the first payload byte.
- R5: The payload byte that brings the packet's delivered count to `pay_len` (the marker is not counted, and `pay_len` is at least 1) carries `out_last` = 1. The packet is then closed, and later bytes are ignored as in R2.
- R6: Inside a packet, a `start_code` byte followed by a byte that is not `start_code` abandons the open packet. `drop` pulses for one cycle in the cycle after the second byte is sampled. That second byte is delivered in the same cycle as the first payload byte of a new packet, with a new count and a restarted timeout, and with `out_last` set if `pay_len` is 1.
- R7: If a packet is opened at a clock edge E and is not completed by edge E+`tmo_limit`, then `drop` and `rx_reset` are both 1 for one cycle, starting right after edge E+`tmo_limit` (`tmo_limit` is at least 1). A byte sampled at that edge that completes the packet wins instead, with no drop. Any other byte sampled at that edge is ignored.
- R8: After a timeout, all bytes are ignored, and produce no output and no drop, until a `start_code` byte opens a new packet.
- R9: `out_valid` is only high in the cycle after a valid input byte. `out_last` is only high together with `out_valid`. `rx_reset` is only high together with `drop`, and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe from the serial receiver |
| in_data | input | DATA_W | Received byte |
| start_code | input | DATA_W | Reserved packet marker value |
| pay_len | input | LEN_W | Payload bytes per packet, marker excluded, at least 1 |
| tmo_limit | input | TMO_W | Packet watchdog limit in clock cycles, at least 1 |
| out_valid | output | 1 | Payload byte strobe |
| out_data | output | DATA_W | Payload byte |
| out_last | output | 1 | Marks the final payload byte of a packet |
| drop | output | 1 | One-cycle pulse: the packet being collected is void |
| rx_reset | output | 1 | One-cycle pulse: clear the serial receiver after a timeout |

## Verification
The checker assumes that `start_code`, `pay_len` and `tmo_limit` stay constant while a packet is open, and that `pay_len` and `tmo_limit` are never 0. Without that, the relation between a delivered byte and the byte sampled one cycle earlier would not hold. The stimulus changes these settings only after a packet has closed or timed out, and always uses nonzero values. The vector table keeps every packet well inside the watchdog limit. Timeouts are produced only by the directed tests, which use short limits.

// File: rtl/pkt_deframer_pkg.sv
package pkt_deframer_pkg;

   // Receive state: hunting for a marker, collecting payload, or holding
   // a marker whose meaning depends on the next byte.
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_BODY = 2'd1,
      ST_ESC  = 2'd2
   } dfr_state_e;

endpackage

// File: rtl/dfr_timer.sv
// Per-packet watchdog: cleared on arm, counts while a packet is open,
// saturates at its maximum value.
module dfr_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};
   localparam logic [TMO_W:0]   ONE_X   = {{TMO_W{1'b0}}, 1'b1};

   logic [TMO_W-1:0] elapsed;
   logic [TMO_W:0]   elapsed_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elapsed <= '0;
      end else if (arm) begin
         elapsed <= '0;
      end else if (run && (elapsed != CNT_MAX)) begin
         elapsed <= elapsed + 1'b1;
      end
   end

   always_comb begin
      elapsed_nx = {1'b0, elapsed} + ONE_X;
      expire     = run && (elapsed_nx >= {1'b0, limit});
   end
endmodule

// File: rtl/dfr_len_count.sv
// Payload counter: restart loads 0 or 1, depending on whether a byte is
// delivered in the same cycle.
module dfr_len_count #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             inc,
   output logic [LEN_W-1:0] count
);
   localparam logic [LEN_W-1:0] ONE_L = {{(LEN_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (restart) begin
         count <= inc ? ONE_L : '0;
      end else if (inc) begin
         count <= count + ONE_L;
      end
   end
endmodule

// File: rtl/dfr_fsm.sv
// Unstuffing state machine with registered outputs.
module dfr_fsm
   import pkt_deframer_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [DATA_W-1:0] start_code,
   input  logic [LEN_W-1:0]  pay_len,
   input  logic [LEN_W-1:0]  count,
   input  logic              expire,
   output logic              arm,
   output logic              emit,
   output logic              open_pkt,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              drop,
   output logic              rx_reset
);
   localparam logic [LEN_W-1:0] ONE_L = {{(LEN_W-1){1'b0}}, 1'b1};

   dfr_state_e        st, st_nx;
   logic              is_mark;
   logic              emit_raw, arm_raw, abandon;
   logic              hit_last, finish, timeout;
   logic              drop_nx;
   logic [DATA_W-1:0] emit_dat;

   assign is_mark  = in_valid && (in_data == start_code);
   assign open_pkt = (st != ST_HUNT);

   always_comb begin
      st_nx    = st;
      emit_raw = 1'b0;
      arm_raw  = 1'b0;
      abandon  = 1'b0;
      emit_dat = in_data;
      unique case (st)
         ST_HUNT: begin
            if (is_mark) begin
               st_nx   = ST_BODY;
               arm_raw = 1'b1;
            end
         end
         ST_BODY: begin
            if (in_valid) begin
               if (is_mark) st_nx    = ST_ESC;
               else         emit_raw = 1'b1;
            end
         end
         ST_ESC: begin
            if (in_valid) begin
               emit_raw = 1'b1;
               st_nx    = ST_BODY;
               if (is_mark) begin
                  emit_dat = start_code;
               end else begin
                  abandon = 1'b1;
                  arm_raw = 1'b1;
               end
            end
         end
         default: st_nx = ST_HUNT;
      endcase

      hit_last = arm_raw ? (pay_len == ONE_L) : ((count + ONE_L) == pay_len);
      finish   = emit_raw && hit_last;
      if (finish) st_nx = ST_HUNT;

      timeout = expire && !finish;
      if (timeout) st_nx = ST_HUNT;

      emit    = emit_raw && !timeout;
      arm     = arm_raw && !timeout;
      drop_nx = timeout || (abandon && !timeout);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_HUNT;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
         drop      <= 1'b0;
         rx_reset  <= 1'b0;
      end else begin
         st        <= st_nx;
         out_valid <= emit;
         if (emit) out_data <= emit_dat;
         out_last  <= finish;
         drop      <= drop_nx;
         rx_reset  <= timeout;
      end
   end
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer #(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 8,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [DATA_W-1:0] start_code,
   input  logic [LEN_W-1:0]  pay_len,
   input  logic [TMO_W-1:0]  tmo_limit,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              drop,
   output logic              rx_reset
);
   if (DATA_W < 2) begin : g_bad_data_w
      $error("pkt_deframer: DATA_W must be at least 2");
   end
   if (LEN_W < 1) begin : g_bad_len_w
      $error("pkt_deframer: LEN_W must be at least 1");
   end
   if (TMO_W < 1) begin : g_bad_tmo_w
      $error("pkt_deframer: TMO_W must be at least 1");
   end

   logic             arm, emit, open_pkt, expire;
   logic [LEN_W-1:0] count;

   dfr_timer #(.TMO_W(TMO_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (arm),
      .run    (open_pkt),
      .limit  (tmo_limit),
      .expire (expire)
   );

   dfr_len_count #(.LEN_W(LEN_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (arm),
      .inc     (emit),
      .count   (count)
   );

   dfr_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .start_code (start_code),
      .pay_len    (pay_len),
      .count      (count),
      .expire     (expire),
      .arm        (arm),
      .emit       (emit),
      .open_pkt   (open_pkt),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_last   (out_last),
      .drop       (drop),
      .rx_reset   (rx_reset)
   );
endmodule

// File: rtl/dfr_checks.sv
module dfr_checks #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_last,
   input logic              drop,
   input logic              rx_reset
);
   p_last_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   p_rxrst_with_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reset |-> drop);

   p_quiet_after_tmo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reset |=> (!out_valid && !rx_reset));

   p_valid_needs_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   p_data_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data == $past(in_data)));
endmodule

bind pkt_deframer dfr_checks #(.DATA_W(DATA_W)) u_dfr_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_last  (out_last),
   .drop      (drop),
   .rx_reset  (rx_reset)
);

// File: tb/pkt_deframer_test.sv
module pkt_deframer_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid;
   logic [7:0] in_data;
   logic [7:0] start_code;
   logic [7:0] pay_len;
   logic [15:0] tmo_limit;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_last;
   logic       drop;
   logic       rx_reset;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   pkt_deframer uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .start_code(start_code), .pay_len(pay_len), .tmo_limit(tmo_limit),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .drop(drop), .rx_reset(rx_reset)
   );

   // {req[3:0], v, data[7:0], exp_v, exp_data[7:0], exp_last, exp_drop, exp_rst}
   // start_code = 8'h7E, pay_len = 3, tmo_limit = 20
   localparam int NV = 21;
   localparam logic [24:0] VEC [NV] = '{
      {4'd2, 1'b1, 8'h11, 1'b0, 8'h00, 3'b000}, // R2 junk before marker
      {4'd2, 1'b1, 8'h7E, 1'b0, 8'h00, 3'b000}, // R2 marker opens
      {4'd3, 1'b1, 8'hA1, 1'b1, 8'hA1, 3'b000}, // R3
      {4'd9, 1'b0, 8'h00, 1'b0, 8'h00, 3'b000}, // R9 gap
      {4'd4, 1'b1, 8'h7E, 1'b0, 8'h00, 3'b000}, // R4 first of pair
      {4'd4, 1'b1, 8'h7E, 1'b1, 8'h7E, 3'b000}, // R4 pair folded
      {4'd5, 1'b1, 8'hB2, 1'b1, 8'hB2, 3'b100}, // R5 last
      {4'd5, 1'b1, 8'h33, 1'b0, 8'h00, 3'b000}, // R5 ignored after close
      {4'd2, 1'b1, 8'h7E, 1'b0, 8'h00, 3'b000}, // R2
      {4'd3, 1'b1, 8'h44, 1'b1, 8'h44, 3'b000}, // R3
      {4'd6, 1'b1, 8'h7E, 1'b0, 8'h00, 3'b000}, // R6 lone marker
      {4'd6, 1'b1, 8'h55, 1'b1, 8'h55, 3'b010}, // R6 abandon + first byte
      {4'd6, 1'b1, 8'h66, 1'b1, 8'h66, 3'b000}, // R6
      {4'd5, 1'b1, 8'h77, 1'b1, 8'h77, 3'b100}, // R5
      {4'd2, 1'b1, 8'h7E, 1'b0, 8'h00, 3'b000}, // R2
      {4'd4, 1'b1, 8'h7E, 1'b0, 8'h00, 3'b000}, // R4
      {4'd4, 1'b1, 8'h7E, 1'b1, 8'h7E, 3'b000}, // R4 folded first payload
      {4'd4, 1'b1, 8'h7E, 1'b0, 8'h00, 3'b000}, // R4
      {4'd4, 1'b1, 8'h7E, 1'b1, 8'h7E, 3'b000}, // R4
      {4'd4, 1'b1, 8'h7E, 1'b0, 8'h00, 3'b000}, // R4
      {4'd5, 1'b1, 8'h7E, 1'b1, 8'h7E, 3'b100}  // R5
   };

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // Called at a falling edge: drive, then wait to the next falling edge.
   task automatic step(input logic v, input logic [7:0] d);
      in_valid = v;
      in_data  = d;
      @(negedge clk);
   endtask

   task automatic chk(input logic ev, input logic [7:0] ed, input logic el,
                      input logic edr, input logic ers, input string tag);
      n_chk++;
      if (out_valid !== ev || (ev && out_data !== ed) || out_last !== el ||
          drop !== edr || rx_reset !== ers) begin
         n_fail++;
         $display("FAIL %s actual v=%b d=%h l=%b drop=%b rst=%b expected v=%b d=%h l=%b drop=%b rst=%b",
                  tag, out_valid, out_data, out_last, drop, rx_reset, ev, ed, el, edr, ers);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
      start_code = 8'h7E; pay_len = 8'd3; tmo_limit = 16'd20;
      repeat (3) @(negedge clk);
      chk(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R1 after release");

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][20], VEC[i][19:12]);
         chk(VEC[i][11], VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0],
             $sformatf("R%0d vector %0d", VEC[i][24:21], i));
      end

      // R7: timeout with limit 5, one payload byte then silence
      tmo_limit = 16'd5;
      step(1'b1, 8'h7E); chk(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R7 open");
      step(1'b1, 8'h01); chk(1'b1, 8'h01, 1'b0, 1'b0, 1'b0, "R7 byte");
      for (int k = 0; k < 3; k++) begin
         step(1'b0, 8'h00); chk(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R7 waiting");
      end
      step(1'b0, 8'h00); chk(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R7 expiry");
      // R8: ignored until next marker
      step(1'b1, 8'h02); chk(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R8 ignored");
      step(1'b1, 8'h03); chk(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R8 ignored");
      step(1'b1, 8'h7E); chk(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R8 marker");
      step(1'b1, 8'h09); chk(1'b1, 8'h09, 1'b0, 1'b0, 1'b0, "R8 resumed");
      step(1'b1, 8'h0A); chk(1'b1, 8'h0A, 1'b0, 1'b0, 1'b0, "R8 resumed");
      step(1'b1, 8'h0B); chk(1'b1, 8'h0B, 1'b1, 1'b0, 1'b0, "R8 resumed last");

      // R7: completion on the expiry edge wins (limit 4)
      tmo_limit = 16'd4;
      step(1'b1, 8'h7E); step(1'b0, 8'h00);
      step(1'b1, 8'hC1); step(1'b1, 8'hC2);
      step(1'b1, 8'hC3); chk(1'b1, 8'hC3, 1'b1, 1'b0, 1'b0, "R7 completion wins");
      step(1'b0, 8'h00); chk(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R7 no late drop");

      // R7: non-completing byte on the expiry edge is ignored
      step(1'b1, 8'h7E); step(1'b1, 8'hD1);
      step(1'b0, 8'h00); step(1'b0, 8'h00);
      step(1'b1, 8'hD2); chk(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R7 byte at expiry");
      step(1'b1, 8'hD3); chk(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R8 after expiry");

      // R6 with single-byte packets: abandon delivers a complete packet
      tmo_limit = 16'd20; pay_len = 8'd1;
      step(1'b1, 8'h7E); step(1'b1, 8'h7E);
      step(1'b1, 8'hE5); chk(1'b1, 8'hE5, 1'b1, 1'b1, 1'b0, "R6 restart len 1");
      step(1'b1, 8'h7E);
      step(1'b1, 8'h11); chk(1'b1, 8'h11, 1'b1, 1'b0, 1'b0, "R5 len 1");

      summary();
      $finish;
   end
endmodule